// File: doc/BRIEF.md
# Paired-Byte Word Write Bus Controller

This block turns a stream of byte-wide table-write requests into word writes on an external multiplexed 16-bit address/data bus. Each request carries one data byte and a 21-bit byte pointer. A request to an even pointer only parks its byte in a holding latch. The external bus still runs a cycle for it, but no strobe is issued and the AD lines float during the data portion. A request to the odd pointer that follows it runs the real word write. The word address is shown first and latched by ALE. Then the 16-bit word is driven, with the new byte on the upper lane and the parked byte on the lower lane. One high-side write strobe is pulsed and both byte-lane selects are asserted.

Every accepted request occupies the bus for a fixed three-clock cycle, which is signalled on `busy`. Requests presented while `busy` is high are not taken. If an odd write arrives without a matching even write for the same word, the word write still runs with whatever the holding latch contains. A sticky flag records that this happened. The upper address lines A[19:16] are driven only when the wide-address option is selected.

Top module: `wordpair_bus_ctrl`

## Requirements
- R1: While reset is active and directly after it, `ce_n`, `oe_n`, `wrh_n`, `wrl_n`, `ub_n` and `lb_n` are high; `ale`, `ad_oe`, `ahi_oe`, `ba0`, `busy` and `unpaired` are low.
- R2: A request is taken on a rising clock edge where `req_valid` is high and `busy` is low. `busy` is then high for exactly three clocks. A request presented while `busy` is high is ignored and leaves the holding latch unchanged.
- R3: In the first clock of a cycle, `ale` is high, `ad_oe` is high and `ad_out` equals pointer bits [16:1]. `ce_n` is low in all three clocks. `oe_n` is never low.
- R4: A request with pointer bit 0 = 0 loads its byte into the holding latch. In its second and third clocks `ad_oe` is low, and `wrh_n`, `ub_n` and `lb_n` stay high.
- R5: A request with pointer bit 0 = 1 drives `ad_out` = {request byte, holding latch} with `ad_oe` high in its second and third clocks.
- R6: `wrh_n` is low only in the second clock of an odd-pointer cycle, for exactly one clock. `wrl_n` is never low.
- R7: `ub_n` and `lb_n` are both low in the second and third clocks of an odd-pointer cycle.
- R8: `ba0` equals pointer bit 0 throughout a cycle and is low when idle.
- R9: With the wide-address option on (default), `ahi_oe` is high through the cycle with `ahi_out` = pointer bits [20:17]. With the option off, `ahi_oe` is never high.
- R10: An odd-pointer request whose word differs from the last unconsumed even request, or that has no such even request, still runs the word write with the current latch contents and sets `unpaired`. `unpaired` then stays high until reset.
- R11: Reset clears the holding latch to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Table-write request present |
| req_ptr | input | 21 | Byte pointer of the request |
| req_data | input | 8 | Data byte of the request |
| busy | output | 1 | Bus cycle in progress |
| unpaired | output | 1 | Sticky flag for an unpaired odd write |
| ad_out | output | 16 | Multiplexed address/data value |
| ad_oe | output | 1 | Drive enable for the AD lines |
| ahi_out | output | 4 | Upper address lines A[19:16] |
| ahi_oe | output | 1 | Drive enable for the upper address lines |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low (held inactive) |
| wrh_n | output | 1 | High write strobe, active low |
| wrl_n | output | 1 | Low write strobe, active low (unused) |
| ub_n | output | 1 | Upper byte select, active low |
| lb_n | output | 1 | Lower byte select, active low |
| ba0 | output | 1 | Byte-address line, pointer bit 0 |

## Verification
Matched even/odd pairs at low, high and all-ones pointers show that the word address and both data lanes are placed correctly and that the upper address lines follow the top pointer bits. An odd write issued first after reset tells a cleared latch from stale data and sets the flag. An even/odd pair that straddles two different words sets the flag and proves the old latch byte is reused. A later correct pair then shows that the flag is sticky. An even request injected while the bus is busy tells an ignored request from one that silently overwrote the latch, because the next odd write exposes the latch on the lower lane.

// File: rtl/wpb_pkg.sv
`timescale 1ns/1ps
package wpb_pkg;

   // Phases of one fixed-length external bus cycle.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_STRB = 2'd2,
      PH_HOLD = 2'd3
   } phase_t;

   // Snapshot of an accepted request, held for the whole bus cycle.
   typedef struct packed {
      logic        odd;
      logic [19:0] word;
      logic [15:0] data;
   } cycle_t;

endpackage

// File: rtl/wpb_pair_track.sv
`timescale 1ns/1ps
module wpb_pair_track #(
   parameter int PTR_W  = 21,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [PTR_W-1:0]  ptr,
   input  logic [BYTE_W-1:0] data,
   output logic [BYTE_W-1:0] latch_q,
   output logic              unpaired
);

   localparam int ADR_W = PTR_W - 1;

   logic             armed_q;
   logic [ADR_W-1:0] armed_word_q;
   logic             is_odd;
   logic [ADR_W-1:0] req_word;
   logic             match;

   assign is_odd   = ptr[0];
   assign req_word = ptr[PTR_W-1:1];
   assign match    = armed_q && (armed_word_q == req_word);

   // Holding latch: written by even-pointer requests only.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (take && !is_odd) begin
         latch_q <= data;
      end
   end

   // Pairing memory: which word the latch byte belongs to.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q      <= 1'b0;
         armed_word_q <= '0;
      end else if (take) begin
         armed_q      <= !is_odd;
         armed_word_q <= req_word;
      end
   end

   // Sticky record of any odd write without its matching even half.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unpaired <= 1'b0;
      end else if (take && is_odd && !match) begin
         unpaired <= 1'b1;
      end
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(unpaired)) else $error("unpaired flag cleared");          // R10
   AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(take && !ptr[0]) |=> $stable(latch_q)) else $error("latch moved"); // R2

endmodule

// File: rtl/wpb_sequencer.sv
`timescale 1ns/1ps
module wpb_sequencer
   import wpb_pkg::*;
#(
   parameter int PTR_W  = 21,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [PTR_W-1:0]  req_ptr,
   input  logic [BYTE_W-1:0] req_data,
   input  logic [BYTE_W-1:0] latch_q,
   output logic              take,
   output logic              busy,
   output phase_t            phase,
   output cycle_t            cyc
);

   localparam int ADR_W  = PTR_W - 1;
   localparam int WORD_W = 2 * BYTE_W;

   phase_t phase_d;

   assign busy = (phase != PH_IDLE);
   assign take = req_valid && !busy;

   always_comb begin
      phase_d = phase;
      unique case (phase)
         PH_IDLE: if (take) phase_d = PH_ADDR;
         PH_ADDR: phase_d = PH_STRB;
         PH_STRB: phase_d = PH_HOLD;
         PH_HOLD: phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
      end else begin
         phase <= phase_d;
      end
   end

   // Capture the request; the odd half combines with the parked byte.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc <= '0;
      end else if (take) begin
         cyc.odd  <= req_ptr[0];
         cyc.word <= 20'(req_ptr[PTR_W-1:1]);
         cyc.data <= 16'({req_data, latch_q});
      end
   end

   initial begin
      if (ADR_W != 20 || WORD_W != 16)
         $error("wpb_sequencer: snapshot type needs 21-bit pointer and 8-bit bytes");
   end

   AST_PH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_ADDR |=> phase == PH_STRB) else $error("order");    // R2
   AST_PH_STRB: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_STRB |=> phase == PH_HOLD) else $error("order");    // R2
   AST_PH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_HOLD |=> phase == PH_IDLE) else $error("order");    // R2

endmodule

// File: rtl/wpb_pin_drv.sv
`timescale 1ns/1ps
module wpb_pin_drv
   import wpb_pkg::*;
#(
   parameter int ADR_W     = 20,
   parameter int WORD_W    = 16,
   parameter bit WIDE_ADDR = 1'b1
) (
   input  phase_t            phase,
   input  cycle_t            cyc,
   output logic [WORD_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [ADR_W-WORD_W-1:0] ahi_out,
   output logic              ahi_oe,
   output logic              ale,
   output logic              ce_n,
   output logic              oe_n,
   output logic              wrh_n,
   output logic              wrl_n,
   output logic              ub_n,
   output logic              lb_n,
   output logic              ba0
);

   localparam int HI_W = ADR_W - WORD_W;

   logic active;
   logic data_ph;

   assign active  = (phase != PH_IDLE);
   assign data_ph = (phase == PH_STRB) || (phase == PH_HOLD);

   always_comb begin
      ale    = (phase == PH_ADDR);
      ce_n   = !active;
      oe_n   = 1'b1;
      wrl_n  = 1'b1;
      wrh_n  = !((phase == PH_STRB) && cyc.odd);
      ub_n   = !(data_ph && cyc.odd);
      lb_n   = !(data_ph && cyc.odd);
      ba0    = active && cyc.odd;
      ad_oe  = (phase == PH_ADDR) || (data_ph && cyc.odd);
      ad_out = '0;
      if (phase == PH_ADDR)          ad_out = cyc.word[WORD_W-1:0];
      else if (data_ph && cyc.odd)   ad_out = cyc.data;
   end

   generate
      if (WIDE_ADDR) begin : g_wide
         assign ahi_oe  = active;
         assign ahi_out = active ? cyc.word[ADR_W-1:WORD_W] : '0;
      end else begin : g_narrow
         assign ahi_oe  = 1'b0;
         assign ahi_out = '0;
      end
   endgenerate

   initial begin
      if (HI_W < 1) $error("wpb_pin_drv: no upper address lines");
   end

endmodule

// File: rtl/wordpair_bus_ctrl.sv
`timescale 1ns/1ps
module wordpair_bus_ctrl
   import wpb_pkg::*;
#(
   parameter int PTR_W     = 21,
   parameter int BYTE_W    = 8,
   parameter bit WIDE_ADDR = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [PTR_W-1:0]             req_ptr,
   input  logic [BYTE_W-1:0]            req_data,
   output logic                         busy,
   output logic                         unpaired,
   output logic [2*BYTE_W-1:0]          ad_out,
   output logic                         ad_oe,
   output logic [PTR_W-2*BYTE_W-2:0]    ahi_out,
   output logic                         ahi_oe,
   output logic                         ale,
   output logic                         ce_n,
   output logic                         oe_n,
   output logic                         wrh_n,
   output logic                         wrl_n,
   output logic                         ub_n,
   output logic                         lb_n,
   output logic                         ba0
);

   localparam int ADR_W  = PTR_W - 1;
   localparam int WORD_W = 2 * BYTE_W;

   logic [BYTE_W-1:0] latch_q;
   logic              take;
   phase_t            phase;
   cycle_t            cyc;

   initial begin
      if (BYTE_W < 1) $error("wordpair_bus_ctrl: BYTE_W must be positive");
      if (ADR_W <= WORD_W) $error("wordpair_bus_ctrl: pointer too narrow");
   end

   wpb_pair_track #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .ptr      (req_ptr),
      .data     (req_data),
      .latch_q  (latch_q),
      .unpaired (unpaired)
   );

   wpb_sequencer #(.PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ptr   (req_ptr),
      .req_data  (req_data),
      .latch_q   (latch_q),
      .take      (take),
      .busy      (busy),
      .phase     (phase),
      .cyc       (cyc)
   );

   wpb_pin_drv #(.ADR_W(ADR_W), .WORD_W(WORD_W), .WIDE_ADDR(WIDE_ADDR)) u_pins (
      .phase   (phase),
      .cyc     (cyc),
      .ad_out  (ad_out),
      .ad_oe   (ad_oe),
      .ahi_out (ahi_out),
      .ahi_oe  (ahi_oe),
      .ale     (ale),
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .wrh_n   (wrh_n),
      .wrl_n   (wrl_n),
      .ub_n    (ub_n),
      .lb_n    (lb_n),
      .ba0     (ba0)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> ce_n && wrh_n && !ad_oe && !ale && !ba0) else $error("idle"); // R1
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ale) else $error("start");                         // R2
   AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale && busy && !ce_n) else $error("ale");                 // R3
   AST_CE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ce_n) else $error("ce");                                 // R3
   AST_EVEN_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !ale && !ba0 |-> !ad_oe && wrh_n && ub_n && lb_n) else $error("even"); // R4
   AST_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wrh_n |=> wrh_n && busy) else $error("strobe");                   // R6
   AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      !wrh_n |-> $past(ale)) else $error("strobe place");                // R6
   AST_BOTH_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      !wrh_n |-> !ub_n && !lb_n && ad_oe && ba0) else $error("lanes");   // R7

endmodule

// File: tb/test_wordpair_bus_ctrl.sv
`timescale 1ns/1ps
module test_wordpair_bus_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [20:0] req_ptr = '0;
   logic [7:0]  req_data = '0;

   logic        busy, unpaired, ad_oe, ahi_oe, ale, ce_n, oe_n;
   logic        wrh_n, wrl_n, ub_n, lb_n, ba0;
   logic [15:0] ad_out;
   logic [3:0]  ahi_out;

   logic        n_busy, n_unpaired, n_ad_oe, n_ahi_oe, n_ale, n_ce_n, n_oe_n;
   logic        n_wrh_n, n_wrl_n, n_ub_n, n_lb_n, n_ba0;
   logic [15:0] n_ad_out;
   logic [3:0]  n_ahi_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // bench model of the requirements
   logic [7:0]  m_latch = '0;
   logic        m_armed = 1'b0;
   logic [19:0] m_word = '0;
   logic        m_flag = 1'b0;

   always #10 clk = ~clk;

   wordpair_bus_ctrl i_wordpair_bus_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
      .req_data(req_data), .busy(busy), .unpaired(unpaired), .ad_out(ad_out),
      .ad_oe(ad_oe), .ahi_out(ahi_out), .ahi_oe(ahi_oe), .ale(ale),
      .ce_n(ce_n), .oe_n(oe_n), .wrh_n(wrh_n), .wrl_n(wrl_n), .ub_n(ub_n),
      .lb_n(lb_n), .ba0(ba0)
   );

   wordpair_bus_ctrl #(.WIDE_ADDR(1'b0)) i_wordpair_bus_ctrl_narrow (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ptr(req_ptr),
      .req_data(req_data), .busy(n_busy), .unpaired(n_unpaired), .ad_out(n_ad_out),
      .ad_oe(n_ad_oe), .ahi_out(n_ahi_out), .ahi_oe(n_ahi_oe), .ale(n_ale),
      .ce_n(n_ce_n), .oe_n(n_oe_n), .wrh_n(n_wrh_n), .wrl_n(n_wrl_n), .ub_n(n_ub_n),
      .lb_n(n_lb_n), .ba0(n_ba0)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string tag);
      check(busy == 1'b0, "R2", {tag, " busy"}, 32'(busy), 0);
      check(ce_n && wrh_n && wrl_n && ub_n && lb_n && oe_n, "R1",
            {tag, " strobes"}, {26'd0, ce_n, wrh_n, wrl_n, ub_n, lb_n, oe_n}, 32'h3f);
      check(!ale && !ad_oe && !ahi_oe, "R1", {tag, " drives"},
            {29'd0, ale, ad_oe, ahi_oe}, 0);
      check(ba0 == 1'b0, "R8", {tag, " ba0 idle"}, 32'(ba0), 0);
      check(unpaired == m_flag, "R10", {tag, " flag"}, 32'(unpaired), 32'(m_flag));
   endtask

   task automatic do_reset();
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(ce_n && wrh_n && ub_n && lb_n && !ale && !ad_oe && !busy && !unpaired,
            "R1", "in reset", {24'd0, ce_n, wrh_n, ub_n, lb_n, ale, ad_oe, busy, unpaired},
            32'hf0);
      rst_n = 1'b1;
      m_latch = '0; m_armed = 1'b0; m_word = '0; m_flag = 1'b0;
      @(negedge clk);
      check_idle("after reset");
   endtask

   // One table write, checked in all three bus clocks and the idle clock after.
   // If inject is set, another request is offered while busy (R2).
   task automatic run_write(input logic [20:0] ptr, input logic [7:0] d,
                            input bit inject, input logic [20:0] iptr,
                            input logic [7:0] idat);
      logic        odd;
      logic [19:0] word;
      logic [15:0] exp_data;
      odd      = ptr[0];
      word     = ptr[20:1];
      exp_data = {d, m_latch};
      if (odd) begin
         if (!(m_armed && m_word == word)) m_flag = 1'b1;
         m_armed = 1'b0;
      end else begin
         m_latch = d;
         m_armed = 1'b1;
      end
      m_word = word;

      @(negedge clk);
      req_valid = 1'b1; req_ptr = ptr; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      // address clock
      check(ale && ad_oe, "R3", "ale/ad_oe addr", {30'd0, ale, ad_oe}, 3);
      check(ad_out == word[15:0], "R3", "address lines", 32'(ad_out), 32'(word[15:0]));
      check(!ce_n && oe_n, "R3", "ce/oe addr", {30'd0, ce_n, oe_n}, 1);
      check(busy, "R2", "busy addr", 32'(busy), 1);
      check(ba0 == odd, "R8", "ba0 addr", 32'(ba0), 32'(odd));
      check(ahi_oe && ahi_out == word[19:16], "R9", "upper lines",
            {27'd0, ahi_oe, ahi_out}, {27'd1, word[19:16]});
      check(!n_ahi_oe, "R9", "narrow upper enable", 32'(n_ahi_oe), 0);
      if (inject) begin
         req_valid = 1'b1; req_ptr = iptr; req_data = idat;
      end
      @(negedge clk);
      req_valid = 1'b0;
      // strobe clock
      check(wrh_n == !odd, "R6", "wrh strobe", 32'(wrh_n), 32'(!odd));
      check(wrl_n, "R6", "wrl unused", 32'(wrl_n), 1);
      check(ad_oe == odd, odd ? "R5" : "R4", "ad_oe data1", 32'(ad_oe), 32'(odd));
      if (odd) check(ad_out == exp_data, "R5", "data word", 32'(ad_out), 32'(exp_data));
      check(ub_n == !odd && lb_n == !odd, odd ? "R7" : "R4", "lanes data1",
            {30'd0, ub_n, lb_n}, odd ? 0 : 3);
      check(!ce_n && !ale && busy, "R3", "ce data1", {29'd0, ce_n, ale, busy}, 1);
      check(ba0 == odd, "R8", "ba0 data1", 32'(ba0), 32'(odd));
      @(negedge clk);
      // hold clock
      check(wrh_n, "R6", "wrh released", 32'(wrh_n), 1);
      check(ad_oe == odd, odd ? "R5" : "R4", "ad_oe data2", 32'(ad_oe), 32'(odd));
      if (odd) check(ad_out == exp_data, "R5", "data word hold", 32'(ad_out), 32'(exp_data));
      check(ub_n == !odd && lb_n == !odd, odd ? "R7" : "R4", "lanes data2",
            {30'd0, ub_n, lb_n}, odd ? 0 : 3);
      check(!ce_n && busy && ahi_oe, "R3", "ce data2", {29'd0, ce_n, busy, ahi_oe}, 3);
      @(negedge clk);
      check_idle("end of cycle");
   endtask

   task automatic t_odd_after_reset();
      do_reset();
      run_write(21'h000003, 8'hA5, 1'b0, '0, '0);   // R11: low lane 00, R10 flag
      check(unpaired, "R10", "flag on lone odd", 32'(unpaired), 1);
   endtask

   task automatic t_pairs();
      do_reset();
      run_write(21'h012344, 8'h11, 1'b0, '0, '0);
      run_write(21'h012345, 8'h22, 1'b0, '0, '0);
      run_write(21'h1FFFFE, 8'hFF, 1'b0, '0, '0);
      run_write(21'h1FFFFF, 8'h00, 1'b0, '0, '0);
      run_write(21'h000000, 8'h5A, 1'b0, '0, '0);
      run_write(21'h000001, 8'hC3, 1'b0, '0, '0);
      check(!unpaired, "R10", "no flag for pairs", 32'(unpaired), 0);
   endtask

   task automatic t_mismatch();
      do_reset();
      run_write(21'h000010, 8'h77, 1'b0, '0, '0);
      run_write(21'h000021, 8'h88, 1'b0, '0, '0);   // other word: uses 77
      check(unpaired, "R10", "flag on mismatch", 32'(unpaired), 1);
      run_write(21'h000040, 8'h12, 1'b0, '0, '0);
      run_write(21'h000041, 8'h34, 1'b0, '0, '0);
      check(unpaired, "R10", "flag sticky", 32'(unpaired), 1);
   endtask

   task automatic t_busy_ignore();
      do_reset();
      run_write(21'h000100, 8'h3C, 1'b1, 21'h000102, 8'hEE);
      check(!busy, "R2", "injected not started", 32'(busy), 0);
      run_write(21'h000101, 8'h4B, 1'b0, '0, '0);   // low lane must still be 3C
      check(!unpaired, "R2", "pair intact after inject", 32'(unpaired), 0);
   endtask

   initial begin
      t_odd_after_reset();
      t_pairs();
      t_mismatch();
      t_busy_ignore();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule